// File: doc/BRIEF.md
# Table-Programmable State Machine

This block is a general state machine whose whole behaviour comes from a small writable table. It has no fixed transition or output logic. The table row is chosen by the current state value joined with the current input word. That row gives the next state and the output bits. The same instance can therefore act as any machine that fits its state, input and output widths, for example a sequence detector, a lock or a protocol tracker, just by loading a different table.

A controller first holds the machine idle with `run_en` low. While idle it loads the initial-state value and the table rows through a simple write port, then raises `run_en`. While running, each clock edge moves the state register to the next-state field of the selected row. The output can be taken straight from the selected row in the same cycle, which gives input-dependent (Mealy) behaviour. A build parameter can register the output instead. If every row of a state carries the same output field, the output depends only on the state (Moore behaviour).

Top module: `tprog_fsm`

## Requirements
- R1: The table holds 2^(IN_W+ST_W) rows. The row index is {state, input}, with the state bits in the most significant positions. Each row is ST_W+OUT_W bits wide, with the next-state field in the upper ST_W bits and the output field in the lower OUT_W bits.
- R2: A synchronous reset (`rst` high at a clock edge) clears every table row to zero. After reset, the output is zero for every input until rows are written again.
- R3: At each clock edge where `run_en` is high and `rst` is low, the state register takes the next-state field of the row selected by the current state and the current input.
- R4: Reset loads the state register from the initial-state register. The initial-state register keeps its value through reset and holds zero from power-up until it is first written.
- R5: With OUT_MODE = OUT_COMB, `out_bits` equals the output field of the selected row in the same cycle, so it follows a change of `in_bits` without waiting for a clock edge.
- R6: While `run_en` is low, the state register keeps its value unless an initial-state write occurs. A table write is stored at row `cfg_idx` and becomes visible on the next cycle.
- R7: While `run_en` is high, table writes and initial-state writes are ignored. The state follows the previously stored row, and later lookups still return the old contents.
- R8: With OUT_MODE = OUT_REG, `out_bits` shows the output field that was selected in the previous cycle, and it is zero in the cycle after a reset.
- R9: An initial-state write while `run_en` is low stores `init_val` in the initial-state register and also loads it into the state register at that edge.
- R10: When all rows of each state carry the same output field, `out_bits` depends only on the state and is unaffected by the input value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset: clears the table, loads the initial state |
| run_en | input | 1 | High: the machine steps every clock; low: idle and configurable |
| cfg_we | input | 1 | Table row write strobe (honoured only while idle) |
| cfg_idx | input | IN_W+ST_W | Row index for a table write |
| cfg_data | input | ST_W+OUT_W | Row contents {next state, output} |
| init_we | input | 1 | Initial-state write strobe (honoured only while idle) |
| init_val | input | ST_W | New initial-state value |
| in_bits | input | IN_W | Machine input word |
| out_bits | output | OUT_W | Machine output word |
| state_o | output | ST_W | Current state register |

## Verification
A wrong table row or a wrong state value shows up on `out_bits` in the same cycle in combinational mode. On `state_o` it shows up one edge after the faulty lookup. A dropped or misdirected write only becomes visible when the bench later steers the machine onto that row. For this reason the bench sweeps whole tables and runs long random walks, and it also replays a known lock sequence. A reset that fails to clear the table is caught by the idle sweep of every input right after reset, where any nonzero output is an error.

// File: rtl/tpf_pkg.sv
package tpf_pkg;

  // Selects how the output word leaves the block
  typedef enum logic {
    OUT_COMB = 1'b0,  // output field of the selected row, same cycle
    OUT_REG  = 1'b1   // output field captured at the clock edge
  } out_mode_e;

  function automatic int unsigned row_count(input int unsigned iw, input int unsigned sw);
    return 32'd1 << (iw + sw);
  endfunction

endpackage

// File: rtl/tpf_table.sv
module tpf_table #(
  parameter int unsigned IDX_W = 5,
  parameter int unsigned ENT_W = 5,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ENT_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [ENT_W-1:0] rd_data
);

  logic [ENT_W-1:0] rows [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) begin
        rows[k] <= '0;
      end
    end else if (wr_en) begin
      rows[wr_idx] <= wr_data;
    end
  end

  // Asynchronous read: the machine needs the row in the cycle its index forms
  assign rd_data = rows[rd_idx];

endmodule

// File: rtl/tpf_state.sv
module tpf_state #(
  parameter int unsigned ST_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step,
  input  logic [ST_W-1:0] nxt,
  input  logic            ld_init,
  input  logic [ST_W-1:0] init_val,
  output logic [ST_W-1:0] state
);

  // Power-up value only; reset does not touch it
  logic [ST_W-1:0] init_q = '0;

  always_ff @(posedge clk) begin
    if (!rst && ld_init) begin
      init_q <= init_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= init_q;
    end else if (step) begin
      state <= nxt;
    end else if (ld_init) begin
      state <= init_val;
    end
  end

endmodule

// File: rtl/tpf_out.sv
module tpf_out #(
  parameter int unsigned       OUT_W = 2,
  parameter tpf_pkg::out_mode_e MODE = tpf_pkg::OUT_COMB
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OUT_W-1:0] fld,
  output logic [OUT_W-1:0] q
);

  generate
    if (MODE == tpf_pkg::OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          q <= '0;
        end else begin
          q <= fld;
        end
      end
    end else begin : g_comb
      assign q = fld;
    end
  endgenerate

endmodule

// File: rtl/tprog_fsm.sv
module tprog_fsm #(
  parameter int unsigned        IN_W     = 2,
  parameter int unsigned        ST_W     = 3,
  parameter int unsigned        OUT_W    = 2,
  parameter tpf_pkg::out_mode_e OUT_MODE = tpf_pkg::OUT_COMB
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   run_en,
  input  logic                   cfg_we,
  input  logic [IN_W+ST_W-1:0]   cfg_idx,
  input  logic [ST_W+OUT_W-1:0]  cfg_data,
  input  logic                   init_we,
  input  logic [ST_W-1:0]        init_val,
  input  logic [IN_W-1:0]        in_bits,
  output logic [OUT_W-1:0]       out_bits,
  output logic [ST_W-1:0]        state_o
);

  localparam int unsigned IDX_W = IN_W + ST_W;
  localparam int unsigned ENT_W = ST_W + OUT_W;

  logic [ST_W-1:0]  state_q;
  logic [IDX_W-1:0] look_idx;
  logic [ENT_W-1:0] row;
  logic [ST_W-1:0]  nxt_st;
  logic [OUT_W-1:0] lut_out;
  logic             idle;

  assign idle     = ~run_en;
  assign look_idx = {state_q, in_bits};
  assign nxt_st   = row[ENT_W-1:OUT_W];
  assign lut_out  = row[OUT_W-1:0];

  tpf_table #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_table (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_we & idle),
    .wr_idx  (cfg_idx),
    .wr_data (cfg_data),
    .rd_idx  (look_idx),
    .rd_data (row)
  );

  tpf_state #(.ST_W(ST_W)) u_state (
    .clk      (clk),
    .rst      (rst),
    .step     (run_en),
    .nxt      (nxt_st),
    .ld_init  (init_we & idle),
    .init_val (init_val),
    .state    (state_q)
  );

  tpf_out #(.OUT_W(OUT_W), .MODE(OUT_MODE)) u_out (
    .clk (clk),
    .rst (rst),
    .fld (lut_out),
    .q   (out_bits)
  );

  assign state_o = state_q;

endmodule

// File: rtl/tprog_fsm_chk.sv
module tprog_fsm_chk #(
  parameter int unsigned ST_W  = 3,
  parameter int unsigned OUT_W = 2,
  parameter bit          REGD  = 1'b0
) (
  input logic             clk,
  input logic             rst,
  input logic             run_en,
  input logic             init_we,
  input logic [ST_W-1:0]  init_val,
  input logic [ST_W-1:0]  state_o,
  input logic [OUT_W-1:0] out_bits,
  input logic [ST_W-1:0]  nxt_st,
  input logic [OUT_W-1:0] lut_out
);

  assert_step_R3: assert property (@(posedge clk) disable iff (rst)
    run_en |=> state_o == $past(nxt_st));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !init_we) |=> $stable(state_o));

  assert_init_load_R9: assert property (@(posedge clk) disable iff (rst)
    (!run_en && init_we) |=> state_o == $past(init_val));

  assert_cleared_out_R2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> out_bits == '0);

  generate
    if (REGD) begin : g_reg_chk
      assert_reg_out_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> out_bits == $past(lut_out));
    end
  endgenerate

endmodule

bind tprog_fsm tprog_fsm_chk #(
  .ST_W  (ST_W),
  .OUT_W (OUT_W),
  .REGD  (OUT_MODE == tpf_pkg::OUT_REG)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .run_en   (run_en),
  .init_we  (init_we),
  .init_val (init_val),
  .state_o  (state_o),
  .out_bits (out_bits),
  .nxt_st   (nxt_st),
  .lut_out  (lut_out)
);

// File: tb/tb_tprog_fsm.sv
module tb_tprog_fsm;
  import tpf_pkg::*;

  localparam int IW = 2;
  localparam int SW = 3;
  localparam int OW = 2;
  localparam int XW = IW + SW;
  localparam int EW = SW + OW;
  localparam int ND = 1 << XW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst, run_en, cfg_we, init_we;
  logic [XW-1:0] cfg_idx;
  logic [EW-1:0] cfg_data;
  logic [SW-1:0] init_val;
  logic [IW-1:0] in_bits;
  logic [OW-1:0] out_c, out_r;
  logic [SW-1:0] st_c, st_r;

  tprog_fsm #(.IN_W(IW), .ST_W(SW), .OUT_W(OW), .OUT_MODE(OUT_COMB)) dut (
    .clk(clk), .rst(rst), .run_en(run_en), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .init_we(init_we), .init_val(init_val),
    .in_bits(in_bits), .out_bits(out_c), .state_o(st_c));

  tprog_fsm #(.IN_W(IW), .ST_W(SW), .OUT_W(OW), .OUT_MODE(OUT_REG)) dut_r (
    .clk(clk), .rst(rst), .run_en(run_en), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .init_we(init_we), .init_val(init_val),
    .in_bits(in_bits), .out_bits(out_r), .state_o(st_r));

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic [EW-1:0] m_tbl [ND];
  logic [SW-1:0] m_state, m_init;
  logic [OW-1:0] m_rout;
  string otag = "R2";
  string stag = "R4";

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, check before the rising edge,
  // then advance the model as the rising edge will.
  task automatic cyc(input logic r, input logic run, input logic we,
                     input logic [XW-1:0] a, input logic [EW-1:0] d,
                     input logic iwe, input logic [SW-1:0] iv, input logic [IW-1:0] ib);
    logic [EW-1:0] ent;
    @(negedge clk);
    rst = r; run_en = run; cfg_we = we; cfg_idx = a; cfg_data = d;
    init_we = iwe; init_val = iv; in_bits = ib;
    #1;
    ent = m_tbl[{m_state, ib}];
    chk(stag, 32'(st_c), 32'(m_state));
    chk(stag, 32'(st_r), 32'(m_state));
    chk(otag, 32'(out_c), 32'(ent[OW-1:0]));
    chk("R8", 32'(out_r), 32'(m_rout));
    if (r) begin
      for (int k = 0; k < ND; k++) m_tbl[k] = '0;
      m_state = m_init;
      m_rout  = '0;
      stag    = "R4";
    end else begin
      m_rout = ent[OW-1:0];
      if (run) begin
        m_state = ent[EW-1:OW];
        stag = (we || iwe) ? "R3,R7" : "R3";
      end else begin
        if (we) m_tbl[a] = d;
        if (iwe) begin
          m_init  = iv;
          m_state = iv;
          stag    = "R9";
        end else begin
          stag = "R6";
        end
      end
    end
  endtask

  task automatic idle_in(input logic [IW-1:0] ib);
    cyc(1'b0, 1'b0, 1'b0, '0, '0, 1'b0, '0, ib);
  endtask

  task automatic run_in(input logic [IW-1:0] ib);
    cyc(1'b0, 1'b1, 1'b0, '0, '0, 1'b0, '0, ib);
  endtask

  // Lock that opens after the bit sequence 0,1,1,0 on in_bits[0]
  // States: 0 idle, 1 saw 0, 2 saw 01, 3 saw 011, 4 open
  function automatic logic [SW-1:0] lock_next(input int s, input logic b);
    case (s)
      0: return b ? SW'(0) : SW'(1);
      1: return b ? SW'(2) : SW'(1);
      2: return b ? SW'(3) : SW'(1);
      3: return b ? SW'(0) : SW'(4);
      4: return b ? SW'(2) : SW'(1);
      default: return SW'(0);
    endcase
  endfunction

  function automatic logic [OW-1:0] lock_out(input int s);
    return (s == 4) ? OW'(1) : OW'(0);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    rst = 1'b1; run_en = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_data = '0;
    init_we = 1'b0; init_val = '0; in_bits = '0;
    for (int k = 0; k < ND; k++) m_tbl[k] = '0;
    m_state = '0; m_init = '0; m_rout = '0;
    repeat (2) @(posedge clk);

    // R2/R4: fresh machine outputs zero for every input and sits in state 0
    otag = "R2";
    for (int i = 0; i < (1 << IW); i++) idle_in(IW'(i));
    otag = "R3";
    for (int i = 0; i < 6; i++) run_in(IW'($urandom));

    // R1/R9: program the lock table while idle
    otag = "R1";
    cyc(1'b0, 1'b0, 1'b0, '0, '0, 1'b1, SW'(0), '0);
    for (int s = 0; s < (1 << SW); s++) begin
      for (int b = 0; b < (1 << IW); b++) begin
        cyc(1'b0, 1'b0, 1'b1, XW'((s << IW) | b),
            (s < 5) ? {lock_next(s, b[0]), lock_out(s)} : EW'(0),
            1'b0, '0, IW'($urandom));
      end
    end

    // R10: state-only output, the upper input bit is noise
    otag = "R10";
    begin
      logic seq [14] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1,
                        1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
      for (int i = 0; i < 14; i++) begin
        run_in({1'($urandom), seq[i]});
        if (i == 4) begin
          for (int j = 0; j < 3; j++) idle_in(IW'($urandom));
        end
      end
    end

    // R7: writes and init loads during run must be dropped
    otag = "R7";
    for (int i = 0; i < 8; i++) begin
      cyc(1'b0, 1'b1, 1'b1, XW'({m_state, 2'(i)}), EW'($urandom),
          1'b1, SW'($urandom), IW'(i));
    end
    for (int i = 0; i < ND; i++) begin
      cyc(1'b0, 1'b0, 1'b0, '0, '0, 1'b1, SW'(i >> IW), IW'(i));
    end

    // R5/R1: random table, random walk with input-dependent output
    otag = "R5";
    cyc(1'b0, 1'b0, 1'b0, '0, '0, 1'b1, SW'($urandom), '0);
    for (int i = 0; i < ND; i++) begin
      cyc(1'b0, 1'b0, 1'b1, XW'(i), EW'($urandom), 1'b0, '0, IW'($urandom));
    end
    for (int i = 0; i < 400; i++) begin
      logic run;
      run = ($urandom % 10) < 7;
      cyc(1'b0, run, ($urandom % 4) == 0, XW'($urandom), EW'($urandom),
          ($urandom % 8) == 0, SW'($urandom), IW'($urandom));
    end

    // R4/R2: reset keeps the programmed initial state, clears the table
    otag = "R5";
    cyc(1'b0, 1'b0, 1'b0, '0, '0, 1'b1, SW'(5), '0);
    cyc(1'b0, 1'b0, 1'b1, XW'({3'd5, 2'd1}), {SW'(6), OW'(3)}, 1'b0, '0, 2'd1);
    cyc(1'b1, 1'b0, 1'b0, '0, '0, 1'b0, '0, 2'd1);
    cyc(1'b1, 1'b0, 1'b0, '0, '0, 1'b0, '0, 2'd1);
    otag = "R2";
    for (int i = 0; i < (1 << IW); i++) idle_in(IW'(i));
    run_in(2'd1);
    run_in(2'd2);
    idle_in(2'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule